// File: doc/BRIEF.md
# Real-Time Clock and Processor Options Port

This block is a line-frequency real-time clock that shares one device address with a processor options port. A divider turns the system clock into ticks at 50 or 60 per second. While the clock runs, every tick advances a 16-bit counter. When the counter rolls over to zero, the clock raises a ready flag. The clock requests an interrupt when that flag is set and its enable bit in the interrupt mask is set. A separate write port preloads the counter, so software can set how many ticks pass before the next rollover.

The processor reaches the block with single-cycle commands. Each command carries an operation class (control, skip test, output or input) and a 4-bit function code. Control commands start and stop the clock. Skip tests report on the clock interrupt request and on the memory parity error line. Output commands load the 16-bit interrupt mask or a processor status word. The status word holds carry, precision, extend and a 5-bit shift count. Turning extend off is delayed: the command only arms a pending clear, and the clear takes effect on the next strobe from the processor. Any function code the block does not decode is reported as illegal and has no effect.

Top module: `rtc_opts`

## Requirements
- R1: A control command (io_op=0) with function 0 clears ready. If the clock is stopped, it starts the clock and reloads the divider, so the first tick lands exactly CLK_HZ/TICK_HZ cycles after the command edge. If the clock is already running, the divider phase is left alone.
- R2: A control command with function 2 clears ready and stops the clock. A stopped clock leaves the counter unchanged.
- R3: Each tick adds one to the counter, modulo 2^16. Ready is set when the result is zero, and only then. Ready stays set until a control command or reset clears it.
- R4: Ticks come every CLK_HZ/TICK_HZ system cycles. TICK_HZ must be 50 or 60, and any other value fails elaboration.
- R5: clk_irq is high when ready is set and mask bit CLK_IRQ_BIT is set. A skip test (io_op=1) with function 0 raises io_skip when clk_irq is low.
- R6: A skip test with function 2 (octal 02) raises io_skip when par_err is low. Function 10 (octal 012) raises io_skip when par_err is high.
- R7: An output command (io_op=2) with function 0 copies io_wdata into the mask on the command edge.
- R8: An output command with function 8 (octal 010) loads the status word. Carry takes bit 15. Precision takes bit 14 when HAS_PREC is 1 and stays 0 otherwise. The shift count takes bits 4:0. If bit 13 is set, extend goes to 1 and any pending clear is cancelled. If bit 13 is clear, a pending clear is armed and extend is left as it is.
- R9: ext_off_stb clears extend and the pending clear, but only while a clear is pending; with no clear pending it does nothing. On an edge that also loads the status word, the load wins.
- R10: Any other combination of operation and function, including every input (io_op=3) command, raises io_bad in the same cycle and changes no state. io_skip and io_bad are combinational and are low while io_valid is low.
- R11: cnt_we loads cnt_wdata into the counter on the next edge. The load wins over a tick on the same edge, and that tick then neither increments the counter nor sets ready.
- R12: Reset (rst_n low, synchronous) clears ready, the mask, the counter and the status word, and stops the clock.
- R13: When a control command lands on the same edge as a tick that wraps the counter to zero, ready ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_valid | input | 1 | Command present this cycle |
| io_op | input | 2 | Operation class: 0 control, 1 skip test, 2 output, 3 input |
| io_fn | input | 4 | Function code |
| io_wdata | input | 16 | Data for output commands |
| io_skip | output | 1 | Skip condition true (combinational) |
| io_bad | output | 1 | Illegal function (combinational) |
| cnt_we | input | 1 | Counter preload strobe |
| cnt_wdata | input | 16 | Counter preload value |
| cnt_q | output | 16 | Tick counter |
| par_err | input | 1 | Memory parity error flag |
| ext_off_stb | input | 1 | One-cycle strobe that applies a pending extend clear |
| mask_q | output | 16 | Interrupt enable mask |
| clk_ready | output | 1 | Clock ready flag |
| clk_run | output | 1 | Clock is ticking |
| clk_irq | output | 1 | Clock interrupt request |
| carry_q | output | 1 | Carry bit |
| prec_q | output | 1 | Precision flag |
| ext_q | output | 1 | Extend bit |
| shift_q | output | 5 | Shift count |

## Verification
io_skip and io_bad are combinational, so the bench samples them one time unit after it drives a command, before the edge. Mask, status, counter and ready results are due on the edge that accepts the command, and the bench reads them at the next falling edge. Tick results are due exactly CLK_HZ/TICK_HZ edges after a start. The bench counts falling edges from the start command and checks that the counter is unchanged one edge before the tick and has moved on the tick edge. The conflict cases are placed on a tick edge in the same way: a preload against a tick, a control command against a wrapping tick, and a status load against the extend strobe.

// File: rtl/rtc_opts.sv
module rtc_opts #(
  parameter int unsigned CLK_HZ      = 1_000_000,
  parameter int unsigned TICK_HZ     = 60,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SHIFT_W     = 5,
  parameter int unsigned CLK_IRQ_BIT = 3,
  parameter bit          HAS_PREC    = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_valid,
  input  logic [1:0]         io_op,
  input  logic [3:0]         io_fn,
  input  logic [CNT_W-1:0]   io_wdata,
  output logic               io_skip,
  output logic               io_bad,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   cnt_wdata,
  output logic [CNT_W-1:0]   cnt_q,
  input  logic               par_err,
  input  logic               ext_off_stb,
  output logic [CNT_W-1:0]   mask_q,
  output logic               clk_ready,
  output logic               clk_run,
  output logic               clk_irq,
  output logic               carry_q,
  output logic               prec_q,
  output logic               ext_q,
  output logic [SHIFT_W-1:0] shift_q
);
  localparam int unsigned DIV   = CLK_HZ / TICK_HZ;
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);
  localparam logic [1:0] OP_CTL = 2'd0, OP_SKS = 2'd1, OP_OUT = 2'd2;

  if (TICK_HZ != 50 && TICK_HZ != 60) begin : g_rate_check
    $error("TICK_HZ must be 50 or 60");
  end
  if (DIV < 2) begin : g_div_check
    $error("CLK_HZ too low for the tick rate");
  end

  logic ctl, sks, outc;
  logic ctl_go, ctl_halt, sks_irq, sks_nopar, sks_par, out_mask, out_stat;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_inc;
  logic tick, ext_pend;

  assign ctl  = io_valid && io_op == OP_CTL;
  assign sks  = io_valid && io_op == OP_SKS;
  assign outc = io_valid && io_op == OP_OUT;

  assign ctl_go    = ctl  && io_fn == 4'h0;
  assign ctl_halt  = ctl  && io_fn == 4'h2;
  assign sks_irq   = sks  && io_fn == 4'h0;
  assign sks_nopar = sks  && io_fn == 4'h2;
  assign sks_par   = sks  && io_fn == 4'hA;
  assign out_mask  = outc && io_fn == 4'h0;
  assign out_stat  = outc && io_fn == 4'h8;

  assign io_bad  = io_valid && !(ctl_go || ctl_halt || sks_irq || sks_nopar ||
                                 sks_par || out_mask || out_stat);
  assign io_skip = (sks_irq && !clk_irq) || (sks_nopar && !par_err) || (sks_par && par_err);

  assign clk_irq = clk_ready && mask_q[CLK_IRQ_BIT];
  assign tick    = clk_run && div_q == '0;
  assign cnt_inc = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_run <= 1'b0;
      div_q   <= '0;
    end else begin
      if (ctl_halt)    clk_run <= 1'b0;
      else if (ctl_go) clk_run <= 1'b1;
      if (ctl_go && !clk_run) div_q <= DIV_LAST;
      else if (tick)          div_q <= DIV_LAST;
      else if (clk_run)       div_q <= div_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      clk_ready <= 1'b0;
    end else begin
      if (cnt_we)    cnt_q <= cnt_wdata;
      else if (tick) cnt_q <= cnt_inc;
      if (tick && !cnt_we && cnt_inc == '0) clk_ready <= 1'b1;
      else if (ctl_go || ctl_halt)          clk_ready <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (out_mask) mask_q <= io_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q  <= 1'b0;
      prec_q   <= 1'b0;
      ext_q    <= 1'b0;
      ext_pend <= 1'b0;
      shift_q  <= '0;
    end else if (out_stat) begin
      carry_q <= io_wdata[15];
      prec_q  <= HAS_PREC ? io_wdata[14] : 1'b0;
      shift_q <= io_wdata[SHIFT_W-1:0];
      if (io_wdata[13]) begin
        ext_q    <= 1'b1;
        ext_pend <= 1'b0;
      end else begin
        ext_pend <= 1'b1;
      end
    end else if (ext_off_stb && ext_pend) begin
      ext_q    <= 1'b0;
      ext_pend <= 1'b0;
    end
  end
endmodule

module rtc_opts_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SHIFT_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               io_valid,
  input logic [1:0]         io_op,
  input logic [3:0]         io_fn,
  input logic [CNT_W-1:0]   io_wdata,
  input logic               io_bad,
  input logic               cnt_we,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               ext_off_stb,
  input logic [CNT_W-1:0]   mask_q,
  input logic               clk_ready,
  input logic               clk_run,
  input logic               carry_q,
  input logic               ext_q,
  input logic [SHIFT_W-1:0] shift_q
);
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_op == 2'd0 && io_fn == 4'h0) |=> clk_run);

  p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_op == 2'd0 && io_fn == 4'h2) |=> !clk_run);

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_we) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + 1'b1);

  p_wrap_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_we) && $past(cnt_q) == '1 && cnt_q == '0) |-> clk_ready);

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_op == 2'd2 && io_fn == 4'h0) |=> mask_q == $past(io_wdata));

  p_ext_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_op == 2'd2 && io_fn == 4'h8 && io_wdata[13]) |=> ext_q);

  p_ext_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_q) |-> $past(ext_off_stb));

  p_bad_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_bad |=> ($stable(mask_q) && $stable(carry_q) && $stable(shift_q)));
endmodule

bind rtc_opts rtc_opts_chk #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_chk (.*);

// File: tb/tb_rtc_opts.sv
module tb_rtc_opts;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 600;
  localparam int TICK_HZ = 60;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int IRQ_BIT = 3;
  localparam int NV = 13;
  // {op[2], fn[4], data[16], par, exp_skip, exp_bad}
  localparam logic [24:0] VEC [NV] = '{
    {2'd2, 4'h0, 16'h1234, 1'b0, 1'b0, 1'b0},
    {2'd1, 4'h0, 16'h0000, 1'b0, 1'b1, 1'b0},
    {2'd1, 4'h2, 16'h0000, 1'b0, 1'b1, 1'b0},
    {2'd1, 4'h2, 16'h0000, 1'b1, 1'b0, 1'b0},
    {2'd1, 4'hA, 16'h0000, 1'b1, 1'b1, 1'b0},
    {2'd1, 4'hA, 16'h0000, 1'b0, 1'b0, 1'b0},
    {2'd1, 4'h1, 16'h0000, 1'b0, 1'b0, 1'b1},
    {2'd0, 4'h1, 16'h0000, 1'b0, 1'b0, 1'b1},
    {2'd0, 4'h4, 16'h0000, 1'b0, 1'b0, 1'b1},
    {2'd2, 4'h1, 16'hBEEF, 1'b0, 1'b0, 1'b1},
    {2'd3, 4'h0, 16'h0000, 1'b0, 1'b0, 1'b1},
    {2'd2, 4'h9, 16'hFFFF, 1'b0, 1'b0, 1'b1},
    {2'd1, 4'h8, 16'h0000, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic io_valid = 1'b0, cnt_we = 1'b0, par_err = 1'b0, ext_off_stb = 1'b0;
  logic [1:0] io_op = '0;
  logic [3:0] io_fn = '0;
  logic [15:0] io_wdata = '0, cnt_wdata = '0;
  logic io_skip, io_bad, clk_ready, clk_run, clk_irq, carry_q, prec_q, ext_q;
  logic [15:0] cnt_q, mask_q;
  logic [4:0] shift_q;
  int checks = 0, errors = 0;
  bit done = 0;
  logic sk, bd;
  logic [15:0] base;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_opts #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CLK_IRQ_BIT(IRQ_BIT)) dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_op(io_op), .io_fn(io_fn),
    .io_wdata(io_wdata), .io_skip(io_skip), .io_bad(io_bad), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .par_err(par_err), .ext_off_stb(ext_off_stb),
    .mask_q(mask_q), .clk_ready(clk_ready), .clk_run(clk_run), .clk_irq(clk_irq),
    .carry_q(carry_q), .prec_q(prec_q), .ext_q(ext_q), .shift_q(shift_q));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; the command covers the next rising edge.
  task automatic issue(input logic [1:0] op, input logic [3:0] fn, input logic [15:0] d,
                       output logic s, output logic b);
    io_valid = 1'b1; io_op = op; io_fn = fn; io_wdata = d;
    #1; s = io_skip; b = io_bad;
    @(negedge clk);
    io_valid = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] d);
    cnt_we = 1'b1; cnt_wdata = d;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic strobe();
    ext_off_stb = 1'b1;
    @(negedge clk);
    ext_off_stb = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 ready", 16'(clk_ready), 16'd0);
    chk("R12 run", 16'(clk_run), 16'd0);
    chk("R12 mask", mask_q, 16'h0);
    chk("R12 cnt", cnt_q, 16'h0);
    chk("R12 status", {carry_q, prec_q, ext_q, shift_q}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: decode of skip tests and illegal functions (R5 R6 R7 R10)
    for (int i = 0; i < NV; i++) begin
      par_err = VEC[i][2];
      issue(VEC[i][24:23], VEC[i][22:19], VEC[i][18:3], sk, bd);
      chk($sformatf("R6 R10 vec%0d skip", i), 16'(sk), 16'(VEC[i][1]));
      chk($sformatf("R10 vec%0d bad", i), 16'(bd), 16'(VEC[i][0]));
    end
    par_err = 1'b0;
    chk("R7 mask kept", mask_q, 16'h1234);
    chk("R10 status untouched", {carry_q, ext_q, shift_q}, 16'h0);
    chk("R10 not started", 16'(clk_run), 16'd0);

    // R11 preload while stopped, R2 stopped counter holds
    wr_cnt(16'hFFFD);
    chk("R11 preload", cnt_q, 16'hFFFD);
    repeat (2) @(negedge clk);
    chk("R2 stopped hold", cnt_q, 16'hFFFD);

    // R1 R4 first tick exactly DIV edges after start
    issue(2'd0, 4'h0, 16'h0, sk, bd);
    chk("R1 running", 16'(clk_run), 16'd1);
    repeat (DIV-1) @(negedge clk);
    chk("R4 before tick", cnt_q, 16'hFFFD);
    @(negedge clk);
    chk("R4 on tick", cnt_q, 16'hFFFE);
    repeat (DIV) @(negedge clk);
    chk("R3 no wrap", {15'd0, clk_ready}, 16'd0);
    chk("R4 second tick", cnt_q, 16'hFFFF);
    repeat (DIV) @(negedge clk);
    chk("R3 wrap cnt", cnt_q, 16'h0000);
    chk("R3 wrap ready", 16'(clk_ready), 16'd1);
    chk("R5 irq masked", 16'(clk_irq), 16'd0);
    issue(2'd2, 4'h0, 16'(1 << IRQ_BIT), sk, bd);
    chk("R5 irq on", 16'(clk_irq), 16'd1);
    issue(2'd1, 4'h0, 16'h0, sk, bd);
    chk("R5 no skip with irq", 16'(sk), 16'd0);

    // R2 halt
    issue(2'd0, 4'h2, 16'h0, sk, bd);
    chk("R2 ready cleared", 16'(clk_ready), 16'd0);
    chk("R2 stopped", 16'(clk_run), 16'd0);
    base = cnt_q;
    repeat (3*DIV) @(negedge clk);
    chk("R2 no ticks", cnt_q, base);

    // R1 start while running keeps divider phase
    issue(2'd0, 4'h0, 16'h0, sk, bd);
    repeat (4) @(negedge clk);
    issue(2'd0, 4'h0, 16'h0, sk, bd);
    repeat (DIV-6) @(negedge clk);
    chk("R1 no reload early", cnt_q, base);
    @(negedge clk);
    chk("R1 no reload tick", cnt_q, base + 16'd1);

    // R13 control command on a wrapping tick
    issue(2'd0, 4'h2, 16'h0, sk, bd);
    wr_cnt(16'hFFFF);
    issue(2'd0, 4'h0, 16'h0, sk, bd);
    repeat (DIV-1) @(negedge clk);
    issue(2'd0, 4'h0, 16'h0, sk, bd);
    chk("R13 wrap cnt", cnt_q, 16'h0000);
    chk("R13 ready wins", 16'(clk_ready), 16'd1);

    // R11 preload on a tick edge
    repeat (DIV-1) @(negedge clk);
    wr_cnt(16'h0100);
    chk("R11 write wins", cnt_q, 16'h0100);
    repeat (DIV) @(negedge clk);
    chk("R11 next tick", cnt_q, 16'h0101);

    // R8 R9 status word and delayed extend clear
    issue(2'd2, 4'h8, 16'hE01A, sk, bd);
    chk("R8 load all", {carry_q, prec_q, ext_q, shift_q}, {8'd0, 1'b1, 1'b1, 1'b1, 5'h1A});
    issue(2'd2, 4'h8, 16'h4005, sk, bd);
    chk("R8 ext held", {carry_q, prec_q, ext_q, shift_q}, {8'd0, 1'b0, 1'b1, 1'b1, 5'h05});
    strobe();
    chk("R9 strobe clears", 16'(ext_q), 16'd0);
    issue(2'd2, 4'h8, 16'h2000, sk, bd);
    chk("R8 ext set", 16'(ext_q), 16'd1);
    strobe();
    chk("R9 strobe no pend", 16'(ext_q), 16'd1);
    ext_off_stb = 1'b1;
    issue(2'd2, 4'h8, 16'h0000, sk, bd);
    ext_off_stb = 1'b0;
    chk("R9 load wins", 16'(ext_q), 16'd1);
    strobe();
    chk("R9 later strobe", 16'(ext_q), 16'd0);

    // R12 reset while running
    chk("R12 pre run", 16'(clk_run), 16'd1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 run cleared", 16'(clk_run), 16'd0);
    chk("R12 mask cleared", mask_q, 16'h0);
    chk("R12 cnt cleared", cnt_q, 16'h0);
    repeat (2*DIV) @(negedge clk);
    chk("R12 stays stopped", cnt_q, 16'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule